// File: doc/BRIEF.md
# Fixed-Layout Sample Packet Framer

This block turns one sampling period's worth of multichannel data into a fixed 17-byte packet and hands it out one byte at a time over a valid/ready byte stream, for example to a serial transmitter. A single-cycle start pulse captures six 10-bit channel samples, a 4-bit button vector and an 8-bit protocol version. The block then walks through the packet and advances each byte only when the sink accepts it.

The packet opens with two sync bytes. A version byte and a rolling frame number follow. Twelve sample bytes come next, each channel split into a low byte followed by a high byte. A button byte closes the packet. The frame number belongs to the block: it counts completed packets and wraps around.

Control is a two-state machine. **IDLE** holds valid low. The transition *launch* (IDLE to SEND) happens when start is seen in IDLE; it captures the inputs and points the byte index at the first byte. **SEND** presents the indexed byte with valid high. The transition *advance* (SEND to SEND) moves the index on each accepted byte except the last. The transition *finish* (SEND to IDLE) happens on acceptance of the last byte and bumps the frame number.

Top module: `pkt_framer`

## Requirements
- R1: After a start pulse in IDLE, exactly 17 bytes are offered. valid_o and busy_o rise on the edge that samples start_i, and both fall on the edge that accepts the 17th byte.
- R2: Byte 1 of every packet is 0xA5 and byte 2 is 0x5A.
- R3: Byte 3 is the version_i value captured at start.
- R4: Bytes 5 to 16 carry channels 0 to 5 in order, two bytes each, low byte first. Channel i occupies samples_i[10*i+9:10*i]. The sample is zero-extended to 16 bits, so bits 7:2 of each high byte are zero.
- R5: Byte 17 has button bit k of buttons_i in bit k (bit 0 holds b1, bit 3 holds b4), and bits 7:4 are zero.
- R6: Byte 4 is the frame number. It is 0 after reset, rises by one after every completed packet, and wraps from 255 to 0.
- R7: Samples, buttons and version are captured on the start pulse. Changes on those inputs during a packet do not alter the packet.
- R8: While valid_o is high and ready_i is low, byte_o and valid_o hold steady in the next cycle.
- R9: A start pulse while busy_o is high is ignored. The packet continues unchanged and no extra packet follows.
- R10: During reset and after it, until start, valid_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a packet (acted on only in IDLE) |
| samples_i | input | 60 | Six 10-bit samples, channel i at bits 10*i+9:10*i |
| buttons_i | input | 4 | Button states, b1 at bit 0 |
| version_i | input | 8 | Protocol version byte |
| ready_i | input | 1 | Sink accepts the current byte |
| byte_o | output | 8 | Current packet byte |
| valid_o | output | 1 | byte_o is valid |
| busy_o | output | 1 | A packet is in progress |

## Verification
The framer is tried with four sample sets: all-zero, all-ones, and two mixed bit patterns. All-zero and all-ones separate low-byte bits from high-byte bits and expose any leak into the zeroed upper bits. The mixed patterns catch swapped channels and a reversed low/high order. One packet stalls the sink for several cycles to show the byte holding. Another packet receives a second start and changed inputs partway through, which separates captured data from live inputs. A run of more than 256 packets then shows the frame number wrapping back to zero.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } pkt_state_e;

    localparam logic [7:0] SYNC_A = 8'hA5;
    localparam logic [7:0] SYNC_B = 8'h5A;
    localparam int HDR_BYTES = 4;
endpackage

// File: rtl/pkt_capture.sv
module pkt_capture #(
    parameter int NCH  = 6,
    parameter int SW   = 10,
    parameter int NBTN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [NCH*SW-1:0]   samples_i,
    input  logic [NBTN-1:0]     buttons_i,
    input  logic [7:0]          version_i,
    output logic [NCH*SW-1:0]   samples_q,
    output logic [NBTN-1:0]     buttons_q,
    output logic [7:0]          version_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samples_q <= '0;
            buttons_q <= '0;
            version_q <= '0;
        end else if (load_i) begin
            samples_q <= samples_i;
            buttons_q <= buttons_i;
            version_q <= version_i;
        end
    end

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(samples_q) && $stable(buttons_q) && $stable(version_q)); // R7
endmodule

// File: rtl/pkt_byte_sel.sv
module pkt_byte_sel
    import pkt_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int SW   = 10,
    parameter int NBTN = 4,
    parameter int IW   = 5
) (
    input  logic [IW-1:0]       idx_i,
    input  logic [NCH*SW-1:0]   samples_i,
    input  logic [NBTN-1:0]     buttons_i,
    input  logic [7:0]          version_i,
    input  logic [7:0]          frame_i,
    output logic [7:0]          byte_o
);
    localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int DATA_END = HDR_BYTES + 2 * NCH;

    logic [15:0]   words [NCH];
    logic [IW-1:0] off;
    logic [CW-1:0] ch_sel;

    for (genvar g = 0; g < NCH; g++) begin : g_word
        assign words[g] = 16'(samples_i[g*SW +: SW]);
    end

    assign off    = idx_i - IW'(HDR_BYTES);
    assign ch_sel = CW'(off >> 1);

    always_comb begin
        byte_o = 8'h00;
        if (idx_i == IW'(0)) begin
            byte_o = SYNC_A;
        end else if (idx_i == IW'(1)) begin
            byte_o = SYNC_B;
        end else if (idx_i == IW'(2)) begin
            byte_o = version_i;
        end else if (idx_i == IW'(3)) begin
            byte_o = frame_i;
        end else if (idx_i < IW'(DATA_END)) begin
            byte_o = off[0] ? words[ch_sel][15:8] : words[ch_sel][7:0];
        end else begin
            byte_o = 8'(buttons_i);
        end
    end
endmodule

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
    import pkt_pkg::*;
#(
    parameter int PKT_LEN = 17,
    parameter int IW      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            ready_i,
    output logic            load_o,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o,
    output logic [7:0]      frame_o
);
    localparam logic [IW-1:0] LAST = IW'(PKT_LEN - 1);

    pkt_state_e state_q, state_d;
    logic       last_ack;

    assign last_ack = (state_q == ST_SEND) && ready_i && (idx_o == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_SEND;
            ST_SEND: if (last_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i;
        valid_o = (state_q == ST_SEND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o   <= '0;
            frame_o <= '0;
        end else if (load_o) begin
            idx_o <= '0;
        end else if (state_q == ST_SEND && ready_i) begin
            if (idx_o == LAST) frame_o <= frame_o + 8'd1;
            else               idx_o   <= idx_o + IW'(1);
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> (idx_o <= LAST)); // R1
    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_SEND && idx_o == '0)); // R1
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        last_ack |=> (frame_o == $past(frame_o) + 8'd1)); // R6
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && start_i && !ready_i) |=> (state_q == ST_SEND && $stable(idx_o))); // R9
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int SW   = 10,
    parameter int NBTN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NCH*SW-1:0]   samples_i,
    input  logic [NBTN-1:0]     buttons_i,
    input  logic [7:0]          version_i,
    input  logic                ready_i,
    output logic [7:0]          byte_o,
    output logic                valid_o,
    output logic                busy_o
);
    localparam int PKT_LEN = HDR_BYTES + 2 * NCH + 1;
    localparam int IW      = $clog2(PKT_LEN);

    logic                load;
    logic [IW-1:0]       idx;
    logic [7:0]          frame;
    logic [NCH*SW-1:0]   smp_q;
    logic [NBTN-1:0]     btn_q;
    logic [7:0]          ver_q;

    pkt_ctrl #(.PKT_LEN(PKT_LEN), .IW(IW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
        .load_o(load), .valid_o(valid_o), .idx_o(idx), .frame_o(frame)
    );

    pkt_capture #(.NCH(NCH), .SW(SW), .NBTN(NBTN)) cap_i (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .samples_i(samples_i), .buttons_i(buttons_i), .version_i(version_i),
        .samples_q(smp_q), .buttons_q(btn_q), .version_q(ver_q)
    );

    pkt_byte_sel #(.NCH(NCH), .SW(SW), .NBTN(NBTN), .IW(IW)) sel_i (
        .idx_i(idx), .samples_i(smp_q), .buttons_i(btn_q),
        .version_i(ver_q), .frame_i(frame), .byte_o(byte_o)
    );

    assign busy_o = valid_o;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(byte_o))); // R8
    AST_SYNC_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (byte_o == SYNC_A)); // R2
endmodule

// File: tb/pkt_framer_tb_top.sv
module pkt_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [59:0] samples_i = '0;
    logic [3:0]  buttons_i = '0;
    logic [7:0]  version_i = '0;
    logic        ready_i = 1'b1;
    logic [7:0]  byte_o;
    logic        valid_o, busy_o;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] exp_frame = 8'd0;
    bit   done = 1'b0;

    // {version[7:0], buttons[3:0], samples[59:0]}
    localparam logic [71:0] VEC [0:3] = '{
        72'h01_0_000000000000000,
        72'hFF_F_FFFFFFFFFFFFFFF,
        72'h5C_5_123456789ABCDEF,
        72'h03_A_FEDCBA987654321
    };

    always #2 clk = ~clk;

    pkt_framer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .samples_i(samples_i),
        .buttons_i(buttons_i), .version_i(version_i), .ready_i(ready_i),
        .byte_o(byte_o), .valid_o(valid_o), .busy_o(busy_o)
    );

    function automatic logic [7:0] exp_byte(int k, logic [59:0] s, logic [3:0] b,
                                            logic [7:0] v, logic [7:0] f);
        logic [15:0] w;
        if (k == 0) return 8'hA5;
        if (k == 1) return 8'h5A;
        if (k == 2) return v;
        if (k == 3) return f;
        if (k == 16) return {4'h0, b};
        w = {6'b0, s[((k-4)/2)*10 +: 10]};
        return ((k % 2) == 0) ? w[7:0] : w[15:8];
    endfunction

    function automatic string tag_of(int k);
        if (k < 2)  return "R2";
        if (k == 2) return "R3";
        if (k == 3) return "R6";
        if (k == 16) return "R5";
        return "R4";
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // mode: 0 plain, 1 stall at byte 5, 2 restart and input change at byte 8
    task automatic send(logic [71:0] vec, int mode);
        logic [59:0] s = vec[59:0];
        logic [3:0]  b = vec[63:60];
        logic [7:0]  v = vec[71:64];
        samples_i = s; buttons_i = b; version_i = v;
        ready_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 17; k++) begin
            check(tag_of(k), {7'b0, valid_o, byte_o}, {7'b0, 1'b1, exp_byte(k, s, b, v, exp_frame)});
            if (mode == 1 && k == 5) begin
                ready_i = 1'b0;
                repeat (3) begin
                    @(negedge clk);
                    check("R8", {7'b0, valid_o, byte_o}, {7'b0, 1'b1, exp_byte(k, s, b, v, exp_frame)});
                end
                ready_i = 1'b1;
            end
            if (mode == 2 && k == 8) begin
                start_i = 1'b1;
                samples_i = ~s; buttons_i = ~b; version_i = ~v;
                @(negedge clk);
                start_i = 1'b0;
                check("R7", {7'b0, busy_o, byte_o}, {7'b0, 1'b1, exp_byte(k + 1, s, b, v, exp_frame)});
                k++;
            end
            @(negedge clk);
        end
        check("R1", {14'b0, valid_o, busy_o}, 16'h0000);
        exp_frame = exp_frame + 8'd1;
        if (mode == 2) begin
            repeat (3) begin
                @(negedge clk);
                check("R9", {14'b0, valid_o, busy_o}, 16'h0000);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", {14'b0, valid_o, busy_o}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {14'b0, valid_o, busy_o}, 16'h0000);
        for (int i = 0; i < 4; i++) send(VEC[i], (i == 2) ? 1 : (i == 3) ? 2 : 0);
        // frame number wrap: run until the counter has passed 255
        for (int i = 0; i < 254; i++) send(VEC[i % 4], 0);
        check("R6", {8'b0, exp_frame}, 16'h0002);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule